// File: doc/BRIEF.md
# Per-Queue Descriptor Credit Tracker

This block lives in user logic next to a multi-queue DMA engine and keeps the descriptor credit balance of every queue. The engine sends status updates over a valid/ready stream. Each update names a queue, a ring direction and a count, and carries per-queue attributes. The meaning of the count depends on the invalidate flag. When the flag is clear, the count is the number of newly posted descriptors and is added to the balance. When the flag is set, the count is the engine's own credit total and replaces the balance outright, so both sides agree again.

User logic spends credits through a consume port, which is answered in the same cycle with a grant or a refusal. A query port reads back the balance and the stored attributes of any queue. Updates that name a queue outside the tracked range are discarded and counted.

Top module: `credit_tracker`

## Requirements
- R1: `updReady` is low while `rstN` is low and high at all other times. Each cycle in which `updValid` and `updReady` are both high is one accepted update, so holding valid for N cycles applies the update N times.
- R2: A valid update with invalidate clear and error clear adds its 16-bit count to the 17-bit balance of the named queue and direction.
- R3: An addition that would exceed 131071 leaves the balance at 131071.
- R4: An update with invalidate set and error clear overwrites the balance of the named queue and direction with its count.
- R5: An update with error set leaves the balance unchanged and sets that queue's sticky error bit. Only reset clears the bit.
- R6: Direction 0 (host-to-card) and direction 1 (card-to-host) hold independent balances. An update to one direction leaves the other unchanged.
- R7: Every accepted update stores the queue's mode bit (0 streaming, 1 memory-mapped), enable bit, interrupt-arm bit and 3-bit port number. A query returns these values in the cycle after the update.
- R8: A consume request to an enabled, in-range queue is granted in the same cycle if the balance is at least the amount, and the balance then drops by the amount. Otherwise the request is refused and the balance is unchanged.
- R9: A consume request to a queue whose enable bit is clear is refused.
- R10: When an update and a consume target the same queue and direction in one cycle, the additive update is applied first and the consume is judged against the result. An invalidating update always causes the consume to be refused, and the balance becomes the update's count.
- R11: An update whose queue ID is not below NUM_Q (default 16) changes no queue state and increments an 8-bit drop counter that saturates at 255.
- R12: Reset clears every balance, attribute bit, error bit, port number and the drop counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updValid | input | 1 | Update stream valid |
| updReady | output | 1 | Update stream ready |
| updQid | input | 11 | Queue ID of the update |
| updDir | input | 1 | 0 host-to-card, 1 card-to-host |
| updMm | input | 1 | 0 streaming, 1 memory-mapped |
| updCount | input | 16 | Increment, or absolute total when invalidating |
| updInv | input | 1 | Invalidate / resync flag |
| updEn | input | 1 | Queue enable status |
| updArm | input | 1 | Interrupt-arm status |
| updErr | input | 1 | Producer index overran consumer index |
| updPort | input | 3 | Port number of the queue |
| consValid | input | 1 | Consume request present |
| consQid | input | 11 | Queue ID to spend from |
| consDir | input | 1 | Direction to spend from |
| consAmt | input | 16 | Credits to spend |
| consGrant | output | 1 | Request granted this cycle |
| queryQid | input | 11 | Queue ID to read |
| queryDir | input | 1 | Direction to read |
| queryCredits | output | 17 | Balance of the queried queue and direction |
| queryMm | output | 1 | Stored mode bit |
| queryEn | output | 1 | Stored enable bit |
| queryArm | output | 1 | Stored interrupt-arm bit |
| queryErr | output | 1 | Sticky error bit |
| queryPort | output | 3 | Stored port number |
| dropCount | output | 8 | Saturating count of out-of-range updates |

## Verification
The assertions check on every cycle that:
- a granted consume lowers the targeted balance by exactly the amount;
- an invalidate loads the count;
- an errored update leaves the balance untouched and sets the sticky bit;
- grants never go to disabled queues;
- an invalidate on the consumed target always refuses the consume;
- the drop counter never decreases.

Only the bench scenarios can show the rest:
- the arithmetic of accumulation and saturation;
- the isolation between directions and queues;
- the attribute readback;
- the add-then-check ordering;
- the saturation of the drop counter;
- the full clear on reset.

// File: rtl/credit_tracker_pkg.sv
package credit_tracker_pkg;
  localparam int CRED_W  = 17;
  localparam int COUNT_W = 16;
  localparam int QID_W   = 11;
  localparam int PORT_W  = 3;

  typedef struct packed {
    logic updTake;
    logic updAdd;
    logic updLoad;
    logic updErr;
    logic sameTgt;
    logic consSub;
    logic dropInc;
  } trkStrobe_t;

  function automatic logic [CRED_W-1:0] satAdd(input logic [CRED_W-1:0] a,
                                               input logic [COUNT_W-1:0] b);
    logic [CRED_W:0] s;
    s = {1'b0, a} + {{(CRED_W+1-COUNT_W){1'b0}}, b};
    satAdd = s[CRED_W] ? {CRED_W{1'b1}} : s[CRED_W-1:0];
  endfunction
endpackage

// File: rtl/credit_tracker_ctrl.sv
module credit_tracker_ctrl
  import credit_tracker_pkg::*;
#(
  parameter int NUM_Q = 16,
  parameter int IDX_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               updValid,
  input  logic [QID_W-1:0]   updQid,
  input  logic               updDir,
  input  logic               updInv,
  input  logic               updErr,
  input  logic               consValid,
  input  logic [QID_W-1:0]   consQid,
  input  logic               consDir,
  input  logic [COUNT_W-1:0] consAmt,
  input  logic [CRED_W-1:0]  consAvail,
  input  logic               consEnNext,
  output logic               updReady,
  output logic [IDX_W-1:0]   updIdx,
  output logic [IDX_W-1:0]   consIdx,
  output trkStrobe_t         stb,
  output logic               consGrant
);
  logic updInRange, consInRange, xfer, invHit;

  assign updReady    = rstN;
  assign xfer        = updValid && updReady;
  assign updInRange  = updQid < QID_W'(NUM_Q);
  assign consInRange = consQid < QID_W'(NUM_Q);
  assign updIdx      = updQid[IDX_W-1:0];
  assign consIdx     = consQid[IDX_W-1:0];

  always_comb begin
    stb         = '0;
    stb.updTake = xfer && updInRange;
    stb.dropInc = xfer && !updInRange;
    stb.updAdd  = stb.updTake && !updInv && !updErr;
    stb.updLoad = stb.updTake && updInv && !updErr;
    stb.updErr  = stb.updTake && updErr;
    stb.sameTgt = stb.updTake && consValid && consInRange &&
                  (updIdx == consIdx) && (updDir == consDir);
    invHit      = stb.updLoad && stb.sameTgt;
    consGrant   = consValid && consInRange && consEnNext && !invHit &&
                  (consAvail >= {{(CRED_W-COUNT_W){1'b0}}, consAmt});
    stb.consSub = consGrant;
  end

  // R9: a grant is only ever given to a queue enabled after this cycle's update
  a_r9_grant_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    consGrant |-> consEnNext);
  // R10: an invalidate on the consumed target always refuses the consume
  a_r10_invalidate_refuses: assert property (@(posedge clk) disable iff (!rstN)
    (stb.updLoad && stb.sameTgt) |-> !consGrant);
endmodule

// File: rtl/credit_tracker_dp.sv
module credit_tracker_dp
  import credit_tracker_pkg::*;
#(
  parameter int NUM_Q  = 16,
  parameter int IDX_W  = 4,
  parameter int DROP_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  trkStrobe_t         stb,
  input  logic [IDX_W-1:0]   updIdx,
  input  logic               updDir,
  input  logic               updMm,
  input  logic [COUNT_W-1:0] updCount,
  input  logic               updEn,
  input  logic               updArm,
  input  logic [PORT_W-1:0]  updPort,
  input  logic [IDX_W-1:0]   consIdx,
  input  logic               consDir,
  input  logic [COUNT_W-1:0] consAmt,
  input  logic [IDX_W-1:0]   queryIdx,
  input  logic               queryDir,
  output logic [CRED_W-1:0]  consAvail,
  output logic               consEnNext,
  output logic [CRED_W-1:0]  rdCredits,
  output logic               rdMm,
  output logic               rdEn,
  output logic               rdArm,
  output logic               rdErr,
  output logic [PORT_W-1:0]  rdPort,
  output logic [DROP_W-1:0]  dropCount
);
  logic [CRED_W-1:0] credit [NUM_Q][2];
  logic [NUM_Q-1:0]  mmQ, enQ, armQ, errQ;
  logic [PORT_W-1:0] portQ [NUM_Q];
  logic [DROP_W-1:0] dropQ;

  for (genvar gq = 0; gq < NUM_Q; gq++) begin : g_queue
    logic hitQ;
    assign hitQ = stb.updTake && (updIdx == IDX_W'(gq));

    for (genvar gd = 0; gd < 2; gd++) begin : g_dir
      logic hitU, hitC;
      logic [CRED_W-1:0] nxt;
      assign hitU = hitQ && (updDir == 1'(gd));
      assign hitC = stb.consSub && (consIdx == IDX_W'(gq)) && (consDir == 1'(gd));
      always_comb begin
        nxt = credit[gq][gd];
        if (stb.updAdd && hitU)  nxt = satAdd(nxt, updCount);
        if (stb.updLoad && hitU) nxt = {{(CRED_W-COUNT_W){1'b0}}, updCount};
        if (hitC)                nxt = nxt - {{(CRED_W-COUNT_W){1'b0}}, consAmt};
      end
      always_ff @(posedge clk) begin
        if (!rstN) credit[gq][gd] <= '0;
        else       credit[gq][gd] <= nxt;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        mmQ[gq]   <= 1'b0;
        enQ[gq]   <= 1'b0;
        armQ[gq]  <= 1'b0;
        errQ[gq]  <= 1'b0;
        portQ[gq] <= '0;
      end else if (hitQ) begin
        mmQ[gq]   <= updMm;
        enQ[gq]   <= updEn;
        armQ[gq]  <= updArm;
        portQ[gq] <= updPort;
        if (stb.updErr) errQ[gq] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          dropQ <= '0;
    else if (stb.dropInc && !(&dropQ))  dropQ <= dropQ + 1'b1;
  end

  always_comb begin
    consAvail  = credit[consIdx][consDir];
    consEnNext = enQ[consIdx];
    if (stb.sameTgt && stb.updAdd) consAvail = satAdd(consAvail, updCount);
    if (stb.updTake && updIdx == consIdx) consEnNext = updEn;
  end

  assign rdCredits = credit[queryIdx][queryDir];
  assign rdMm      = mmQ[queryIdx];
  assign rdEn      = enQ[queryIdx];
  assign rdArm     = armQ[queryIdx];
  assign rdErr     = errQ[queryIdx];
  assign rdPort    = portQ[queryIdx];
  assign dropCount = dropQ;

  // checker state: the targets and values seen in the previous cycle
  logic              chkSub, chkLoad, chkErr;
  logic [IDX_W-1:0]  chkCIdx, chkUIdx;
  logic              chkCDir, chkUDir;
  logic [CRED_W-1:0] chkCCred, chkUCred;
  logic [COUNT_W-1:0] chkAmt, chkCount;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkSub <= 1'b0; chkLoad <= 1'b0; chkErr <= 1'b0;
      chkCIdx <= '0; chkUIdx <= '0; chkCDir <= 1'b0; chkUDir <= 1'b0;
      chkCCred <= '0; chkUCred <= '0; chkAmt <= '0; chkCount <= '0;
    end else begin
      chkSub   <= stb.consSub && !stb.sameTgt;
      chkLoad  <= stb.updLoad;
      chkErr   <= stb.updErr && !(stb.consSub && stb.sameTgt);
      chkCIdx  <= consIdx;  chkCDir <= consDir;
      chkUIdx  <= updIdx;   chkUDir <= updDir;
      chkCCred <= credit[consIdx][consDir];
      chkUCred <= credit[updIdx][updDir];
      chkAmt   <= consAmt;  chkCount <= updCount;
    end
  end

  // R8: a granted consume takes exactly its amount away from the balance
  a_r8_consume_subtracts: assert property (@(posedge clk) disable iff (!rstN)
    chkSub |-> credit[chkCIdx][chkCDir] == chkCCred - {{(CRED_W-COUNT_W){1'b0}}, chkAmt});
  // R4: an invalidate replaces the balance with the count
  a_r4_invalidate_loads: assert property (@(posedge clk) disable iff (!rstN)
    chkLoad |-> credit[chkUIdx][chkUDir] == {{(CRED_W-COUNT_W){1'b0}}, chkCount});
  // R5: an errored update keeps the balance and sets the sticky bit
  a_r5_error_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    chkErr |-> (credit[chkUIdx][chkUDir] == chkUCred) && errQ[chkUIdx]);
  // R11: the drop counter never goes down outside reset
  a_r11_drop_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    dropQ >= $past(dropQ));
endmodule

// File: rtl/credit_tracker.sv
module credit_tracker
  import credit_tracker_pkg::*;
#(
  parameter int NUM_Q  = 16,
  parameter int DROP_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        updValid,
  output logic        updReady,
  input  logic [10:0] updQid,
  input  logic        updDir,
  input  logic        updMm,
  input  logic [15:0] updCount,
  input  logic        updInv,
  input  logic        updEn,
  input  logic        updArm,
  input  logic        updErr,
  input  logic [2:0]  updPort,
  input  logic        consValid,
  input  logic [10:0] consQid,
  input  logic        consDir,
  input  logic [15:0] consAmt,
  output logic        consGrant,
  input  logic [10:0] queryQid,
  input  logic        queryDir,
  output logic [16:0] queryCredits,
  output logic        queryMm,
  output logic        queryEn,
  output logic        queryArm,
  output logic        queryErr,
  output logic [2:0]  queryPort,
  output logic [DROP_W-1:0] dropCount
);
  localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  trkStrobe_t        stb;
  logic [IDX_W-1:0]  updIdx, consIdx;
  logic [CRED_W-1:0] consAvail, rdCredits;
  logic              consEnNext, rdMm, rdEn, rdArm, rdErr, queryOk;
  logic [PORT_W-1:0] rdPort;

  credit_tracker_ctrl #(.NUM_Q(NUM_Q), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updQid(updQid),
    .updDir(updDir), .updInv(updInv), .updErr(updErr),
    .consValid(consValid), .consQid(consQid), .consDir(consDir),
    .consAmt(consAmt), .consAvail(consAvail), .consEnNext(consEnNext),
    .updReady(updReady), .updIdx(updIdx), .consIdx(consIdx),
    .stb(stb), .consGrant(consGrant)
  );

  credit_tracker_dp #(.NUM_Q(NUM_Q), .IDX_W(IDX_W), .DROP_W(DROP_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .updIdx(updIdx), .updDir(updDir),
    .updMm(updMm), .updCount(updCount), .updEn(updEn), .updArm(updArm),
    .updPort(updPort), .consIdx(consIdx), .consDir(consDir),
    .consAmt(consAmt), .queryIdx(queryQid[IDX_W-1:0]), .queryDir(queryDir),
    .consAvail(consAvail), .consEnNext(consEnNext), .rdCredits(rdCredits),
    .rdMm(rdMm), .rdEn(rdEn), .rdArm(rdArm), .rdErr(rdErr),
    .rdPort(rdPort), .dropCount(dropCount)
  );

  assign queryOk      = queryQid < QID_W'(NUM_Q);
  assign queryCredits = queryOk ? rdCredits : '0;
  assign queryMm      = queryOk && rdMm;
  assign queryEn      = queryOk && rdEn;
  assign queryArm     = queryOk && rdArm;
  assign queryErr     = queryOk && rdErr;
  assign queryPort    = queryOk ? rdPort : '0;
endmodule

// File: tb/credit_tracker_tb_top.sv
module credit_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        updValid = 1'b0, updDir = 1'b0, updMm = 1'b0, updInv = 1'b0;
  logic        updEn = 1'b0, updArm = 1'b0, updErr = 1'b0;
  logic [10:0] updQid = '0;
  logic [15:0] updCount = '0;
  logic [2:0]  updPort = '0;
  logic        consValid = 1'b0, consDir = 1'b0;
  logic [10:0] consQid = '0;
  logic [15:0] consAmt = '0;
  logic [10:0] queryQid = '0;
  logic        queryDir = 1'b0;
  logic        updReady, consGrant, queryMm, queryEn, queryArm, queryErr;
  logic [16:0] queryCredits;
  logic [2:0]  queryPort;
  logic [7:0]  dropCount;

  int nChk = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  credit_tracker dut_i (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updReady(updReady),
    .updQid(updQid), .updDir(updDir), .updMm(updMm), .updCount(updCount),
    .updInv(updInv), .updEn(updEn), .updArm(updArm), .updErr(updErr),
    .updPort(updPort), .consValid(consValid), .consQid(consQid),
    .consDir(consDir), .consAmt(consAmt), .consGrant(consGrant),
    .queryQid(queryQid), .queryDir(queryDir), .queryCredits(queryCredits),
    .queryMm(queryMm), .queryEn(queryEn), .queryArm(queryArm),
    .queryErr(queryErr), .queryPort(queryPort), .dropCount(dropCount)
  );

  task automatic chk(string tag, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setUpd(int q, bit d, int cnt, bit inv, bit err, bit en,
                        bit arm, bit mm, int port);
    updQid = 11'(q); updDir = d; updCount = 16'(cnt); updInv = inv;
    updErr = err; updEn = en; updArm = arm; updMm = mm; updPort = 3'(port);
  endtask

  task automatic send(int q, bit d, int cnt, bit inv = 0, bit err = 0,
                      bit en = 1, bit arm = 0, bit mm = 0, int port = 0);
    @(negedge clk);
    setUpd(q, d, cnt, inv, err, en, arm, mm, port);
    updValid = 1'b1;
    @(posedge clk); #1;
    updValid = 1'b0;
  endtask

  task automatic consume(int q, bit d, int amt, output bit g);
    @(negedge clk);
    consQid = 11'(q); consDir = d; consAmt = 16'(amt); consValid = 1'b1;
    #1 g = consGrant;
    @(posedge clk); #1;
    consValid = 1'b0;
  endtask

  task automatic credits(int q, bit d, output int c);
    queryQid = 11'(q); queryDir = d;
    #1 c = int'(queryCredits);
  endtask

  task automatic tReset();
    int c;
    #2 chk("R1 ready low in reset", updReady, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1 chk("R1 ready high after reset", updReady, 1);
    credits(0, 0, c); chk("R12 reset balance", c, 0);
    chk("R12 reset drop counter", dropCount, 0);
    chk("R12 reset enable", queryEn, 0);
  endtask

  task automatic tAddAndDirs();
    int c;
    send(3, 0, 10);
    credits(3, 0, c); chk("R2 first add", c, 10);
    send(3, 0, 5);
    credits(3, 0, c); chk("R2 second add", c, 15);
    credits(3, 1, c); chk("R6 other direction untouched", c, 0);
    send(3, 1, 7);
    credits(3, 1, c); chk("R6 dir1 balance", c, 7);
    credits(3, 0, c); chk("R6 dir0 kept", c, 15);
  endtask

  task automatic tAttributes();
    send(5, 1, 0, 0, 0, 1, 1, 1, 5);
    queryQid = 11'd5; #1;
    chk("R7 mode bit", queryMm, 1);
    chk("R7 enable bit", queryEn, 1);
    chk("R7 arm bit", queryArm, 1);
    chk("R7 port", queryPort, 5);
    send(5, 0, 0, 0, 0, 1, 0, 0, 2);
    queryQid = 11'd5; #1;
    chk("R7 mode updated", queryMm, 0);
    chk("R7 arm updated", queryArm, 0);
    chk("R7 port updated", queryPort, 2);
  endtask

  task automatic tConsume();
    bit g; int c;
    consume(3, 0, 4, g); chk("R8 grant 4 of 15", g, 1);
    credits(3, 0, c); chk("R8 balance after grant", c, 11);
    consume(3, 0, 12, g); chk("R8 refuse 12 of 11", g, 0);
    credits(3, 0, c); chk("R8 balance after refusal", c, 11);
    consume(3, 0, 11, g); chk("R8 exact amount granted", g, 1);
    credits(3, 0, c); chk("R8 drained to zero", c, 0);
    credits(3, 1, c); chk("R8 other direction kept", c, 7);
    consume(20, 0, 0, g); chk("R8 out of range queue refused", g, 0);
  endtask

  task automatic tDisabled();
    bit g; int c;
    send(6, 0, 20, 0, 0, 0);
    consume(6, 0, 1, g); chk("R9 disabled queue refused", g, 0);
    credits(6, 0, c); chk("R9 balance kept", c, 20);
  endtask

  task automatic tSaturate();
    int c;
    send(7, 0, 65535);
    send(7, 0, 65535);
    credits(7, 0, c); chk("R3 below ceiling", c, 131070);
    send(7, 0, 5);
    credits(7, 0, c); chk("R3 clipped at ceiling", c, 131071);
    send(7, 0, 1);
    credits(7, 0, c); chk("R3 stays at ceiling", c, 131071);
  endtask

  task automatic tInvalidateAndError();
    int c;
    send(7, 0, 100, 1);
    credits(7, 0, c); chk("R4 invalidate loads count", c, 100);
    send(7, 0, 50, 0, 1);
    credits(7, 0, c); chk("R5 errored count ignored", c, 100);
    chk("R5 error bit set", queryErr, 1);
    send(7, 0, 1);
    credits(7, 0, c); chk("R5 later add applies", c, 101);
    chk("R5 error bit sticky", queryErr, 1);
  endtask

  task automatic tSameCycle();
    bit g; int c;
    send(8, 0, 3);
    @(negedge clk);
    setUpd(8, 0, 5, 0, 0, 1, 0, 0, 0); updValid = 1'b1;
    consQid = 11'd8; consDir = 0; consAmt = 16'd7; consValid = 1'b1;
    #1 g = consGrant;
    @(posedge clk); #1 updValid = 1'b0; consValid = 1'b0;
    chk("R10 consume sees add first", g, 1);
    credits(8, 0, c); chk("R10 balance 3+5-7", c, 1);
    @(negedge clk);
    setUpd(8, 0, 9, 1, 0, 1, 0, 0, 0); updValid = 1'b1;
    consQid = 11'd8; consDir = 0; consAmt = 16'd1; consValid = 1'b1;
    #1 g = consGrant;
    @(posedge clk); #1 updValid = 1'b0; consValid = 1'b0;
    chk("R10 invalidate refuses consume", g, 0);
    credits(8, 0, c); chk("R10 invalidate value kept", c, 9);
  endtask

  task automatic tHandshake();
    int c;
    @(negedge clk);
    setUpd(9, 1, 2, 0, 0, 1, 0, 0, 0); updValid = 1'b1;
    repeat (3) @(posedge clk);
    #1 updValid = 1'b0;
    credits(9, 1, c); chk("R1 three handshakes three adds", c, 6);
  endtask

  task automatic tDrop();
    int c;
    send(16, 0, 40);
    chk("R11 drop counted", dropCount, 1);
    credits(0, 0, c); chk("R11 queue 0 untouched", c, 0);
    @(negedge clk);
    setUpd(1000, 0, 1, 0, 0, 1, 0, 0, 0); updValid = 1'b1;
    repeat (300) @(posedge clk);
    #1 updValid = 1'b0;
    chk("R11 drop counter saturates", dropCount, 255);
  endtask

  task automatic tMidReset();
    int c;
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    credits(3, 1, c); chk("R12 balance cleared", c, 0);
    credits(7, 0, c); chk("R12 ceiling balance cleared", c, 0);
    chk("R12 error bit cleared", queryErr, 0);
    queryQid = 11'd5; #1 chk("R12 port cleared", queryPort, 0);
    chk("R12 drop counter cleared", dropCount, 0);
  endtask

  initial begin
    tReset();
    tAddAndDirs();
    tAttributes();
    tConsume();
    tDisabled();
    tSaturate();
    tInvalidateAndError();
    tSameCycle();
    tHandshake();
    tDrop();
    tMidReset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end
endmodule